// File: doc/BRIEF.md
# DRAM Strobe-Order Cycle Classifier

This block watches the four control strobes of an asynchronous page-mode DRAM (row strobe, column strobe, write enable, output enable) in a fast system clock and works out which operation each row-strobe-low period performs. It never looks at a command code. The operation follows only from the order in which the strobe edges arrive: whether the column strobe was already low when the row strobe fell, what write enable showed at the column strobe fall, whether write enable fell later, how many column strobes occurred, and how long the row strobe stayed low. It is meant as a device-side reference model or protocol checker in a verification environment.

Every output is registered. Each one changes on the clock edge that first samples the strobe change causing it, one clock of latency. The block latches the row address at the row strobe fall and the column address at each column strobe fall. It keeps an internal refresh row counter and decides when the data bus would be driven. It gives a cycle-type code with a one-clock valid strobe when the row strobe rises. The strobes are plain control levels, so there is no valid/ready handshake and no back-pressure. All strobes are active low.

Top module: `dram_cycle_decoder`

## Requirements
- R1: If the column strobe is low on the sample before and on the sample of a row strobe fall, the period is a CAS-before-RAS refresh. `row_addr` takes the refresh counter value and the address pins are ignored. `dq_oe` stays 0, and the report code is 7.
- R2: A row strobe fall with the column strobe high latches `addr` into `row_addr`. If no column strobe falls before the row strobe rises, the report code is 6 (row-only refresh).
- R3: If `we_n` is low on the sample of the first column strobe fall, the cycle is an early write. `col_load` and `wr_load` pulse together, `dq_oe` stays 0 even with `oe_n` low, and the code is 2.
- R4: If `we_n` falls while the column strobe stays low after a read column, `wr_load` pulses one clock. The code is 4 (read-modify-write) if `oe_n` was sampled low since that column, otherwise 3 (delayed write).
- R5: If `we_n` is high at the single column strobe fall, the cycle is a read with code 1. `dq_oe` rises on the clock after `oe_n` is sampled low.
- R6: A second column strobe fall in the same row period latches a new `col_addr` and leaves `row_addr` unchanged. The report code is then 5 (page mode).
- R7: Read data stays driven after the column strobe rises while the row strobe is low. `dq_oe` falls on the first sample with both strobes high, on any sample with `oe_n` high, or on a `we_n` fall while the column strobe is high.
- R8: If a refresh period keeps the row strobe low on more than `SELF_REF_CYCLES` consecutive samples, `self_ref` goes high and the report code is 9.
- R9: The refresh counter resets to 0, advances by one at each valid refresh entry (R1, R11), and wraps from 2047 to 0.
- R10: On the clock after the sample where the row strobe rises, `cyc_valid` is 1 for exactly one clock, with `cyc_type` and `cyc_err`.
- R11: If the column strobe is still held low from a column access of the previous row period when the row strobe falls again, the period is a hidden refresh with code 8. The counter advances and read data stays driven.
- R12: Two conditions are protocol errors and report code 15 with `cyc_err` = 1: the row and column strobes first seen low on the same sample, and a column strobe fall inside a refresh period. The first does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| row_addr | output | ADDR_W | Latched row (pins or refresh counter) |
| col_addr | output | ADDR_W | Latched column |
| col_load | output | 1 | One-clock pulse when a column is latched |
| wr_load | output | 1 | One-clock pulse when write data would be captured |
| dq_oe | output | 1 | Data bus drive decision |
| self_ref | output | 1 | High while in self-refresh |
| cyc_valid | output | 1 | One-clock report strobe after row strobe rise |
| cyc_type | output | 4 | Cycle code (1..9, 15) |
| cyc_err | output | 1 | Protocol-error flag with the report |

## Verification
Two functions of the block can land on the same clock: the row strobe rising and ending one report, and the held column strobe immediately opening a hidden refresh that must keep the data bus driven. The bench provokes this by raising the row strobe during a read with the column strobe held low, then lowering the row strobe again. It judges that the read report arrives with code 1, that the hidden refresh takes the next counter row, and that `dq_oe` never drops until both strobes are high. A second overlap is a row strobe fall and a column strobe fall caught on one sample. The bench judges it as an error that leaves the refresh counter untouched.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [3:0] {
    CYC_NONE    = 4'd0,
    CYC_READ    = 4'd1,
    CYC_EWRITE  = 4'd2,
    CYC_DWRITE  = 4'd3,
    CYC_RMW     = 4'd4,
    CYC_PAGE    = 4'd5,
    CYC_RASONLY = 4'd6,
    CYC_CBR     = 4'd7,
    CYC_HIDDEN  = 4'd8,
    CYC_SELF    = 4'd9,
    CYC_ERR     = 4'd15
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_REF  = 2'd2
  } row_state_e;

  typedef struct packed {
    logic ras_fall;
    logic ras_rise;
    logic cas_fall;
    logic we_fall;
  } strobe_edges_t;

endpackage

// File: rtl/dcd_edges.sv
module dcd_edges
  import dcd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  output logic          cas_q,
  output logic          oe_q,
  output strobe_edges_t ev
);
  localparam int NSTB = 3;

  logic [NSTB-1:0] lvl_now, lvl_prev;

  assign lvl_now = {we_n, cas_n, ras_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '1;
      oe_q     <= 1'b1;
    end else begin
      lvl_prev <= lvl_now;
      oe_q     <= oe_n;
    end
  end

  assign cas_q       = lvl_prev[1];
  assign ev.ras_fall = lvl_prev[0] & ~lvl_now[0];
  assign ev.ras_rise = ~lvl_prev[0] & lvl_now[0];
  assign ev.cas_fall = lvl_prev[1] & ~lvl_now[1];
  assign ev.we_fall  = lvl_prev[2] & ~lvl_now[2];

endmodule

// File: rtl/dcd_refresh.sv
module dcd_refresh #(
  parameter int ROW_W           = 11,
  parameter int SELF_REF_CYCLES = 25000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             start,
  input  logic             in_ref,
  output logic [ROW_W-1:0] ref_row,
  output logic             self_ref
);
  localparam int             TW     = $clog2(SELF_REF_CYCLES + 1);
  localparam logic [TW-1:0]  SR_MAX = TW'(SELF_REF_CYCLES);

  logic [TW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_row  <= '0;
      hold_cnt <= '0;
    end else begin
      if (step) ref_row <= ref_row + 1'b1;
      if (start)                            hold_cnt <= '0;
      else if (in_ref && hold_cnt != SR_MAX) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign self_ref = in_ref && (hold_cnt == SR_MAX);

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ref_row == $past(ref_row) + 1'b1));

  assert_self_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_ref) |-> $past(in_ref));

endmodule

// File: rtl/dcd_dq.sv
module dcd_dq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_col,
  input  logic wr_evt,
  input  logic we_fall_idle,
  input  logic both_high,
  input  logic oe_q,
  output logic dq_oe
);
  logic rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   rd_active <= 1'b0;
    else if (rd_col)                              rd_active <= 1'b1;
    else if (wr_evt || we_fall_idle || both_high) rd_active <= 1'b0;
  end

  assign dq_oe = rd_active & ~oe_q;

  assert_off_both_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    both_high |=> !dq_oe);

endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
  import dcd_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_edges_t    ev,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             cas_q,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [ROW_W-1:0] ref_row,
  input  logic             self_ref,
  output logic [ROW_W-1:0] row_addr,
  output logic [ROW_W-1:0] col_addr,
  output logic             col_load,
  output logic             wr_load,
  output logic             rd_col,
  output logic             wr_evt,
  output logic             we_fall_idle,
  output logic             ref_step,
  output logic             ref_start,
  output logic             in_ref,
  output logic             cyc_valid,
  output logic [3:0]       cyc_type,
  output logic             cyc_err
);
  row_state_e st;
  cyc_e       kind, rep;
  logic [1:0] ncols;
  logic       oe_seen, hidden, err_flag, col_hold;
  logic       cbr_ok, clash, col_evt, ref_cas, late_we, ewr;

  assign cbr_ok       = ev.ras_fall & ~cas_q & ~cas_n;
  assign clash        = ev.ras_fall & cas_q & ~cas_n;
  assign col_evt      = ev.cas_fall & (st == ST_ROW) & ~ras_n;
  assign ref_cas      = ev.cas_fall & (st == ST_REF) & ~ras_n;
  assign rd_col       = col_evt & we_n;
  assign ewr          = col_evt & ~we_n;
  assign late_we      = ev.we_fall & ~cas_n & ~cas_q & ~ras_n &
                        (st == ST_ROW) & (kind == CYC_READ);
  assign wr_evt       = ewr | late_we;
  assign we_fall_idle = ev.we_fall & cas_n;
  assign ref_step     = cbr_ok;
  assign ref_start    = cbr_ok | clash;
  assign in_ref       = (st == ST_REF);

  always_comb begin
    case (st)
      ST_REF:  rep = err_flag ? CYC_ERR : self_ref ? CYC_SELF :
                     hidden ? CYC_HIDDEN : CYC_CBR;
      ST_ROW: begin
        if (ncols == 2'd0)  rep = CYC_RASONLY;
        else if (ncols[1])  rep = CYC_PAGE;
        else                rep = kind;
      end
      default: rep = CYC_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= CYC_NONE;
      ncols     <= '0;
      oe_seen   <= 1'b0;
      hidden    <= 1'b0;
      err_flag  <= 1'b0;
      col_hold  <= 1'b0;
      row_addr  <= '0;
      col_addr  <= '0;
      col_load  <= 1'b0;
      wr_load   <= 1'b0;
      cyc_valid <= 1'b0;
      cyc_type  <= CYC_NONE;
      cyc_err   <= 1'b0;
    end else begin
      col_load  <= col_evt;
      wr_load   <= wr_evt;
      cyc_valid <= ev.ras_rise;

      if (col_evt) begin
        col_addr <= addr;
        if (!ncols[1]) ncols <= ncols + 2'd1;
        kind    <= we_n ? CYC_READ : CYC_EWRITE;
        oe_seen <= 1'b0;
      end else if (!oe_n && kind == CYC_READ) begin
        oe_seen <= 1'b1;
      end

      if (late_we) kind <= oe_seen ? CYC_RMW : CYC_DWRITE;
      if (ref_cas) err_flag <= 1'b1;

      if (cas_n)        col_hold <= 1'b0;
      else if (col_evt) col_hold <= 1'b1;

      if (ev.ras_fall) begin
        ncols   <= '0;
        kind    <= CYC_NONE;
        oe_seen <= 1'b0;
        if (cbr_ok) begin
          st       <= ST_REF;
          row_addr <= ref_row;
          hidden   <= col_hold;
          err_flag <= 1'b0;
        end else if (clash) begin
          st       <= ST_REF;
          hidden   <= 1'b0;
          err_flag <= 1'b1;
        end else begin
          st       <= ST_ROW;
          row_addr <= addr;
          hidden   <= 1'b0;
          err_flag <= 1'b0;
        end
      end

      if (ev.ras_rise) begin
        st       <= ST_IDLE;
        cyc_type <= rep;
        cyc_err  <= (rep == CYC_ERR);
      end
    end
  end

  assert_report_after_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> ($past(ras_n) && !$past(ras_n, 2)));

  assert_cbr_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step |=> (row_addr == $past(ref_row)));

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ADDR_W          = 11,
  parameter int SELF_REF_CYCLES = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic              col_load,
  output logic              wr_load,
  output logic              dq_oe,
  output logic              self_ref,
  output logic              cyc_valid,
  output logic [3:0]        cyc_type,
  output logic              cyc_err
);
  strobe_edges_t     ev;
  logic              cas_q, oe_q;
  logic              rd_col, wr_evt, we_fall_idle;
  logic              ref_step, ref_start, in_ref;
  logic [ADDR_W-1:0] ref_row;

  dcd_edges u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .cas_q(cas_q), .oe_q(oe_q), .ev(ev)
  );

  dcd_refresh #(.ROW_W(ADDR_W), .SELF_REF_CYCLES(SELF_REF_CYCLES)) u_refresh (
    .clk(clk), .rst_n(rst_n), .step(ref_step), .start(ref_start),
    .in_ref(in_ref), .ref_row(ref_row), .self_ref(self_ref)
  );

  dcd_classifier #(.ROW_W(ADDR_W)) u_class (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ras_n(ras_n), .cas_n(cas_n),
    .cas_q(cas_q), .we_n(we_n), .oe_n(oe_n), .addr(addr), .ref_row(ref_row),
    .self_ref(self_ref), .row_addr(row_addr), .col_addr(col_addr),
    .col_load(col_load), .wr_load(wr_load), .rd_col(rd_col), .wr_evt(wr_evt),
    .we_fall_idle(we_fall_idle), .ref_step(ref_step), .ref_start(ref_start),
    .in_ref(in_ref), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_err(cyc_err)
  );

  dcd_dq u_dq (
    .clk(clk), .rst_n(rst_n), .rd_col(rd_col), .wr_evt(wr_evt),
    .we_fall_idle(we_fall_idle), .both_high(ras_n & cas_n), .oe_q(oe_q),
    .dq_oe(dq_oe)
  );

  assert_ewrite_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_load && wr_load) |-> !dq_oe);

endmodule

// File: tb/dram_cycle_decoder_tb_top.sv
module dram_cycle_decoder_tb_top;
  localparam int AW = 11;
  localparam int SR = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] row_addr, col_addr;
  logic col_load, wr_load, dq_oe, self_ref, cyc_valid, cyc_err;
  logic [3:0] cyc_type;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_ref = 0;
  int cycles  = 0;
  bit done    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  dram_cycle_decoder #(.ADDR_W(AW), .SELF_REF_CYCLES(SR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .row_addr(row_addr), .col_addr(col_addr),
    .col_load(col_load), .wr_load(wr_load), .dq_oe(dq_oe),
    .self_ref(self_ref), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_err(cyc_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int next_ref(input int r);
    return (r + 1) % 2048;
  endfunction

  task automatic ras_dn(input int row);
    addr = AW'(row); ras_n = 1'b0; tick();
    chk("R2 row latched from pins", int'(row_addr), row);
    addr = AW'($urandom);
  endtask

  task automatic ras_up(input int typ, input int err);
    ras_n = 1'b1; tick();
    chk("R10 cyc_valid after rise", int'(cyc_valid), 1);
    chk("R10 cyc_type", int'(cyc_type), typ);
    chk("R12 cyc_err", int'(cyc_err), err);
    tick();
    chk("R10 cyc_valid one clock", int'(cyc_valid), 0);
  endtask

  task automatic cas_dn(input int col, input bit we);
    addr = AW'(col); we_n = we; cas_n = 1'b0; tick();
    chk("R5 col latched", int'(col_addr), col);
    chk("R5 col_load", int'(col_load), 1);
    chk("R3 wr_load at col", int'(wr_load), we ? 0 : 1);
    addr = AW'($urandom);
  endtask

  task automatic cas_up();
    cas_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic do_read(input int row, input int col);
    ras_dn(row); cas_dn(col, 1'b1);
    oe_n = 1'b0; tick();
    chk("R5 dq_oe after OE", int'(dq_oe), 1);
    cas_up();
    chk("R7 data held after CAS rise", int'(dq_oe), 1);
    ras_up(1, 0);
    chk("R7 dq off after both high", int'(dq_oe), 0);
    oe_n = 1'b1; tick();
  endtask

  task automatic do_ewrite(input int row, input int col);
    ras_dn(row); oe_n = 1'b0;
    cas_dn(col, 1'b0);
    tick();
    chk("R3 early write keeps dq off", int'(dq_oe), 0);
    cas_up(); ras_up(2, 0);
    oe_n = 1'b1; tick();
  endtask

  task automatic do_late(input int row, input int col, input bit rmw);
    ras_dn(row); cas_dn(col, 1'b1); tick();
    if (rmw) begin
      oe_n = 1'b0; tick();
      chk("R5 rmw read phase dq", int'(dq_oe), 1);
      oe_n = 1'b1; tick();
      chk("R7 OE high disables", int'(dq_oe), 0);
    end
    we_n = 1'b0; tick();
    chk("R4 wr_load on WE fall", int'(wr_load), 1);
    tick();
    chk("R4 wr_load one clock", int'(wr_load), 0);
    we_n = 1'b1; cas_up();
    ras_up(rmw ? 4 : 3, 0);
  endtask

  task automatic do_page(input int row, input int c1, input int c2);
    ras_dn(row); cas_dn(c1, 1'b1); cas_up();
    cas_dn(c2, 1'b1);
    chk("R6 row kept in page", int'(row_addr), row);
    cas_up(); ras_up(5, 0);
  endtask

  task automatic do_rasonly(input int row);
    ras_dn(row); tick(); tick();
    chk("R2 row kept", int'(row_addr), row);
    ras_up(6, 0);
  endtask

  task automatic do_cbr(input int hold, input bit is_self);
    cas_n = 1'b0; addr = AW'($urandom); tick();
    ras_n = 1'b0; tick();
    chk("R1 row from counter", int'(row_addr), exp_ref);
    chk("R1 dq off in refresh", int'(dq_oe), 0);
    exp_ref = next_ref(exp_ref);
    repeat (hold - 1) tick();
    chk("R8 self_ref level", int'(self_ref), is_self ? 1 : 0);
    ras_up(is_self ? 9 : 7, 0);
    chk("R8 self_ref cleared", int'(self_ref), 0);
    cas_up();
  endtask

  task automatic do_hidden(input int row, input int col);
    ras_dn(row); cas_dn(col, 1'b1);
    oe_n = 1'b0; tick();
    ras_up(1, 0);
    chk("R11 data held across RAS high", int'(dq_oe), 1);
    ras_n = 1'b0; tick();
    chk("R11 hidden row from counter", int'(row_addr), exp_ref);
    chk("R11 data held in hidden", int'(dq_oe), 1);
    exp_ref = next_ref(exp_ref);
    tick();
    ras_up(8, 0);
    chk("R11 data still held", int'(dq_oe), 1);
    cas_up();
    chk("R7 off after later rise", int'(dq_oe), 0);
    oe_n = 1'b1; tick();
  endtask

  task automatic do_we_disable(input int row, input int col);
    ras_dn(row); cas_dn(col, 1'b1);
    oe_n = 1'b0; tick();
    cas_up();
    chk("R7 held before WE pulse", int'(dq_oe), 1);
    we_n = 1'b0; tick();
    chk("R7 WE pulse disables", int'(dq_oe), 0);
    chk("R4 no write with CAS high", int'(wr_load), 0);
    we_n = 1'b1; tick();
    ras_up(1, 0);
    oe_n = 1'b1; tick();
  endtask

  task automatic do_clash();
    cas_n = 1'b0; ras_n = 1'b0; tick();
    tick(); tick();
    ras_up(15, 1);
    cas_up();
  endtask

  task automatic do_refcas();
    cas_n = 1'b0; tick();
    ras_n = 1'b0; tick();
    chk("R1 row before error", int'(row_addr), exp_ref);
    exp_ref = next_ref(exp_ref);
    cas_n = 1'b1; tick();
    cas_n = 1'b0; tick();
    chk("R12 no column in refresh", int'(col_load), 0);
    ras_up(15, 1);
    cas_up();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1; tick();
    chk("R9 reset row", int'(row_addr), 0);
    chk("R7 reset dq_oe", int'(dq_oe), 0);
    chk("R10 reset valid", int'(cyc_valid), 0);
    chk("R8 reset self_ref", int'(self_ref), 0);

    do_read(12, 34);
    do_ewrite(2047, 0);
    do_late(100, 200, 1'b0);
    do_late(101, 201, 1'b1);
    do_page(555, 7, 1999);
    do_rasonly(1234);
    do_cbr(3, 1'b0);
    do_hidden(77, 88);
    do_we_disable(5, 6);
    do_clash();
    do_cbr(2, 1'b0);
    do_refcas();
    do_cbr(SR - 10, 1'b0);
    do_cbr(SR + 10, 1'b1);

    for (int i = 0; i < 200; i++) begin
      int k, r, c;
      k = $urandom_range(0, 7);
      r = $urandom_range(0, 2047);
      c = $urandom_range(0, 2047);
      case (k)
        0: do_read(r, c);
        1: do_ewrite(r, c);
        2: do_late(r, c, 1'b0);
        3: do_late(r, c, 1'b1);
        4: do_page(r, c, $urandom_range(0, 2047));
        5: do_rasonly(r);
        6: do_hidden(r, c);
        default: do_cbr($urandom_range(1, 5), 1'b0);
      endcase
    end

    while (exp_ref != 2047) do_cbr(2, 1'b0);
    do_cbr(2, 1'b0);
    chk("R9 counter wrapped", exp_ref, 0);
    do_cbr(2, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule